// File: doc/BRIEF.md
# Calendar Time Advance Counter

This block advances a full time-of-day and calendar record by one second. On every one-second tick it takes the current seconds, minutes, hour, weekday, day-of-month, month, year and century bytes. It returns the updated bytes through a single carry chain that settles within the tick cycle. All eight bytes are written together into output registers, and a one-cycle pulse reports that a new record is available.

Two mode inputs select the arithmetic. One bit selects packed BCD (two decimal digits per byte, each nibble wrapping at ten) or plain binary. The other bit selects 24-hour or 12-hour form; in 12-hour form bit 7 of the hour byte marks afternoon. The surrounding logic owns the stored register bytes. It feeds them in as inputs and writes the outputs back after the pulse. Leap years, daylight saving, alarms and interrupts are not handled here.

Top module: `calendarAdvance`

## Requirements
- R1: While reset (active low) is asserted, all eight output bytes read 0x00 and the update pulse is low.
- R2: Without a tick, the output bytes keep their last values regardless of changes on the input bytes or mode bits.
- R3: The update pulse is high in exactly the cycle after each tick cycle, and the output bytes carry the new record in that same cycle; back-to-back ticks give back-to-back pulses.
- R4: On a tick the seconds byte increments by one; the value 60 (0x60 when BCD mode is 1, decimal 60 when 0) wraps to zero and carries into the minutes.
- R5: A minute carry increments the minutes byte, which wraps at 60 to zero and carries into the hour; without a carry the minutes byte passes through unchanged.
- R6: With the 24-hour bit set, an hour carry increments the hour, which wraps at 24 (0x24 in BCD) to zero and produces a next-day carry.
- R7: With the 24-hour bit clear, an hour byte with bit 7 set is read as afternoon (low seven bits plus 12). After the increment, a 24-hour value of 12 or more is written back as the value minus 12 with bit 7 set, and a smaller value is written back as is; wrapping past 11 pm gives 0x00 and a next-day carry.
- R8: A next-day carry advances the weekday byte modulo 7 (6 becomes 0).
- R9: A next-day carry resets the day-of-month to 1 and carries into the month when the day equals the month length. The month length is 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, 28 for month 2, and 30 for any other code; BCD month codes are 0x01 to 0x12. Otherwise the day increments.
- R10: A month carry increments the month, and month 13 wraps to 1 with a carry into the year.
- R11: A year carry increments the year; in binary 100 wraps to 0, in BCD a carry out of the upper nibble (0x99) wraps to 0x00, and either wrap increments the century byte.
- R12: In BCD mode a low nibble that reaches ten resets to zero and increments the high nibble (0x09 becomes 0x10).
- R13: Bytes above the point where the carry chain stops are copied from the inputs unchanged, even when they hold out-of-range values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-second advance request, one cycle wide |
| bcdMode | input | 1 | 1 = packed BCD bytes, 0 = binary |
| hour24Mode | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with bit 7 as afternoon |
| secIn | input | 8 | Current seconds |
| minIn | input | 8 | Current minutes |
| hourIn | input | 8 | Current hour |
| wdayIn | input | 8 | Current weekday (0 to 6) |
| mdayIn | input | 8 | Current day of month |
| monIn | input | 8 | Current month |
| yearIn | input | 8 | Current year within century |
| centIn | input | 8 | Current century |
| secOut | output | 8 | Updated seconds |
| minOut | output | 8 | Updated minutes |
| hourOut | output | 8 | Updated hour |
| wdayOut | output | 8 | Updated weekday |
| mdayOut | output | 8 | Updated day of month |
| monOut | output | 8 | Updated month |
| yearOut | output | 8 | Updated year |
| centOut | output | 8 | Updated century |
| updPulse | output | 1 | High for one cycle when the outputs hold a new record |

## Verification
The hour conversion of the 12-hour mode and the next-day roll can fall in the same tick. At 11 pm, 59:59, the afternoon decode, the increment past 23, the re-encoding and the weekday and day carries all resolve together. Vectors feeding 0x91 at 59:59, and end-of-year records where the month, year and century wraps coincide with the day wrap, provoke this case. Every output byte of such a tick is compared against the fully rolled-over record computed by hand.

// File: rtl/calendarPkg.sv
package calendarPkg;
  localparam int NIBBLE_W = 4;
  localparam int BYTE_W   = 2 * NIBBLE_W;
  localparam int PM_BIT   = BYTE_W - 1;

  typedef logic [BYTE_W-1:0] byteT;

  localparam byteT RADIX       = 8'd10;
  localparam byteT SEC_LIMIT   = 8'd60;
  localparam byteT MIN_LIMIT   = 8'd60;
  localparam byteT HOUR_LIMIT  = 8'd24;
  localparam byteT HALF_DAY    = 8'd12;
  localparam byteT WEEK_LEN    = 8'd7;
  localparam byteT MONTH_COUNT = 8'd12;
  localparam byteT YEAR_LIMIT  = 8'd100;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic minStep;
    logic hourStep;
    logic dayStep;
    logic monStep;
    logic yearStep;
    logic centStep;
  } stepT;

  // wrap conditions from datapath to control
  typedef struct packed {
    logic secWrap;
    logic minWrap;
    logic hourWrap;
    logic monthEnd;
    logic monWrap;
    logic yearWrap;
  } wrapT;

  function automatic byteT incVal(byteT v, logic bcd);
    logic [NIBBLE_W:0] lo, hi;
    byteT r;
    if (bcd) begin
      lo = {1'b0, v[NIBBLE_W-1:0]} + 5'd1;
      hi = {1'b0, v[BYTE_W-1:NIBBLE_W]};
      if (lo >= 5'd10) begin
        lo = lo - 5'd10;
        hi = hi + 5'd1;
      end
      if (hi >= 5'd10) hi = hi - 5'd10;
      r = {hi[NIBBLE_W-1:0], lo[NIBBLE_W-1:0]};
    end else begin
      r = v + 8'd1;
    end
    return r;
  endfunction

  function automatic logic bcdCarry(byteT v);
    logic [NIBBLE_W:0] lo, hi;
    lo = {1'b0, v[NIBBLE_W-1:0]} + 5'd1;
    hi = {1'b0, v[BYTE_W-1:NIBBLE_W]};
    if (lo >= 5'd10) hi = hi + 5'd1;
    return hi >= 5'd10;
  endfunction

  function automatic byteT decode(byteT v, logic bcd);
    byteT hiPart, loPart;
    hiPart = byteT'(v[BYTE_W-1:NIBBLE_W]);
    loPart = byteT'(v[NIBBLE_W-1:0]);
    return bcd ? (hiPart * RADIX + loPart) : v;
  endfunction

  function automatic byteT encode(byteT v, logic bcd);
    byteT tens, ones;
    tens = v / RADIX;
    ones = v % RADIX;
    return bcd ? {tens[NIBBLE_W-1:0], ones[NIBBLE_W-1:0]} : v;
  endfunction

  function automatic byteT monthLen(byteT m, logic bcd);
    logic ok;
    byteT mb, d;
    ok = !bcd || ((m[NIBBLE_W-1:0] < 4'd10) && (m[BYTE_W-1:NIBBLE_W] < 4'd10));
    mb = decode(m, bcd);
    if (!ok) d = 8'd30;
    else begin
      case (mb)
        8'd1, 8'd3, 8'd5, 8'd7, 8'd8, 8'd10, 8'd12: d = 8'd31;
        8'd4, 8'd6, 8'd9, 8'd11:                    d = 8'd30;
        8'd2:                                       d = 8'd28;
        default:                                    d = 8'd30;
      endcase
    end
    return encode(d, bcd);
  endfunction
endpackage

// File: rtl/calendarCtrl.sv
module calendarCtrl
  import calendarPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  wrapT wrap,
  output stepT step,
  output logic updPulse
);
  // ripple of carries through the calendar fields
  always_comb begin
    step.load     = tickIn;
    step.minStep  = tickIn & wrap.secWrap;
    step.hourStep = step.minStep & wrap.minWrap;
    step.dayStep  = step.hourStep & wrap.hourWrap;
    step.monStep  = step.dayStep & wrap.monthEnd;
    step.yearStep = step.monStep & wrap.monWrap;
    step.centStep = step.yearStep & wrap.yearWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updPulse <= 1'b0;
    else       updPulse <= tickIn;
  end
endmodule

// File: rtl/calendarPath.sv
module calendarPath
  import calendarPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  stepT step,
  input  logic bcd,
  input  logic h24,
  input  byteT secIn,
  input  byteT minIn,
  input  byteT hourIn,
  input  byteT wdayIn,
  input  byteT mdayIn,
  input  byteT monIn,
  input  byteT yearIn,
  input  byteT centIn,
  output wrapT wrap,
  output byteT secOut,
  output byteT minOut,
  output byteT hourOut,
  output byteT wdayOut,
  output byteT mdayOut,
  output byteT monOut,
  output byteT yearOut,
  output byteT centOut
);
  byteT secInc, minInc, hourInc, mdayInc, monInc, yearInc, centInc;
  byteT hourBase, hour24, hourNext24, hourBin, hourNext, wdayNext;
  logic pmIn;
  logic [BYTE_W:0] wdaySum;

  always_comb begin
    secInc = incVal(secIn, bcd);
    minInc = incVal(minIn, bcd);
    wrap.secWrap = (secInc == encode(SEC_LIMIT, bcd));
    wrap.minWrap = (minInc == encode(MIN_LIMIT, bcd));

    // hour: bring to 24-hour form, step, return to the selected form
    pmIn     = !h24 && hourIn[PM_BIT];
    hourBase = {1'b0, hourIn[PM_BIT-1:0]};
    hour24   = pmIn ? encode(decode(hourBase, bcd) + HALF_DAY, bcd) : hourIn;
    hourInc  = incVal(hour24, bcd);
    wrap.hourWrap = (hourInc == encode(HOUR_LIMIT, bcd));
    hourNext24 = wrap.hourWrap ? '0 : hourInc;
    hourBin    = decode(hourNext24, bcd);
    if (h24 || hourBin < HALF_DAY) hourNext = hourNext24;
    else begin
      hourNext = encode(hourBin - HALF_DAY, bcd);
      hourNext[PM_BIT] = 1'b1;
    end

    wdaySum  = {1'b0, wdayIn} + 9'd1;
    wdayNext = byteT'(wdaySum % {1'b0, WEEK_LEN});

    mdayInc = incVal(mdayIn, bcd);
    wrap.monthEnd = (mdayIn == monthLen(monIn, bcd));
    monInc  = incVal(monIn, bcd);
    wrap.monWrap = (monInc == encode(MONTH_COUNT + 8'd1, bcd));
    yearInc = incVal(yearIn, bcd);
    wrap.yearWrap = bcd ? bcdCarry(yearIn) : (yearInc == YEAR_LIMIT);
    centInc = incVal(centIn, bcd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secOut  <= '0;
      minOut  <= '0;
      hourOut <= '0;
      wdayOut <= '0;
      mdayOut <= '0;
      monOut  <= '0;
      yearOut <= '0;
      centOut <= '0;
    end else if (step.load) begin
      secOut  <= wrap.secWrap ? '0 : secInc;
      minOut  <= step.minStep ? (wrap.minWrap ? '0 : minInc) : minIn;
      hourOut <= step.hourStep ? hourNext : hourIn;
      wdayOut <= step.dayStep ? wdayNext : wdayIn;
      mdayOut <= step.dayStep ? (wrap.monthEnd ? 8'd1 : mdayInc) : mdayIn;
      monOut  <= step.monStep ? (wrap.monWrap ? 8'd1 : monInc) : monIn;
      yearOut <= step.yearStep ? (wrap.yearWrap ? '0 : yearInc) : yearIn;
      centOut <= step.centStep ? centInc : centIn;
    end
  end
endmodule

// File: rtl/calendarAdvance.sv
module calendarAdvance
  import calendarPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       bcdMode,
  input  logic       hour24Mode,
  input  logic [7:0] secIn,
  input  logic [7:0] minIn,
  input  logic [7:0] hourIn,
  input  logic [7:0] wdayIn,
  input  logic [7:0] mdayIn,
  input  logic [7:0] monIn,
  input  logic [7:0] yearIn,
  input  logic [7:0] centIn,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] wdayOut,
  output logic [7:0] mdayOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic [7:0] centOut,
  output logic       updPulse
);
  stepT step;
  wrapT wrap;

  calendarCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrap(wrap),
    .step(step), .updPulse(updPulse)
  );

  calendarPath u_path (
    .clk(clk), .rstN(rstN), .step(step), .bcd(bcdMode), .h24(hour24Mode),
    .secIn(secIn), .minIn(minIn), .hourIn(hourIn), .wdayIn(wdayIn),
    .mdayIn(mdayIn), .monIn(monIn), .yearIn(yearIn), .centIn(centIn),
    .wrap(wrap),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
    .mdayOut(mdayOut), .monOut(monOut), .yearOut(yearOut), .centOut(centOut)
  );
endmodule

// File: rtl/calendarChecker.sv
module calendarChecker (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic       bcdMode,
  input logic       hour24Mode,
  input logic [7:0] secIn,
  input logic [7:0] hourIn,
  input logic [7:0] wdayIn,
  input logic [7:0] mdayIn,
  input logic [7:0] centIn,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] wdayOut,
  input logic [7:0] mdayOut,
  input logic [7:0] monOut,
  input logic [7:0] yearOut,
  input logic [7:0] centOut,
  input logic       updPulse
);
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> updPulse); // R3
  AST_NO_PULSE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> !updPulse); // R3
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(secOut) && $stable(minOut) && $stable(hourOut) && $stable(wdayOut)
             && $stable(mdayOut) && $stable(monOut) && $stable(yearOut) && $stable(centOut)); // R2
  AST_SEC_BIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickIn && !bcdMode && secIn < 8'd60 |=> secOut < 8'd60); // R4
  AST_HOUR_BIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickIn && !bcdMode && hour24Mode && hourIn < 8'd24 |=> hourOut < 8'd24); // R6
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickIn && wdayIn < 8'd7 |=> wdayOut < 8'd7); // R8
  AST_MDAY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    tickIn && mdayIn != 8'd0 |=> mdayOut != 8'd0); // R9
  AST_CENT_NEEDS_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> (centOut == $past(centIn)) || (yearOut == 8'd0)); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> !updPulse && secOut == 8'd0 && centOut == 8'd0); // R1
endmodule

bind calendarAdvance calendarChecker u_calendarChecker (.*);

// File: tb/test_calendarAdvance.sv
module test_calendarAdvance;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, bcdMode = 1'b0, hour24Mode = 1'b1;
  logic [7:0] secIn = '0, minIn = '0, hourIn = '0, wdayIn = '0;
  logic [7:0] mdayIn = '0, monIn = '0, yearIn = '0, centIn = '0;
  logic [7:0] secOut, minOut, hourOut, wdayOut, mdayOut, monOut, yearOut, centOut;
  logic updPulse;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  calendarAdvance i_calendarAdvance (.*);

  // {bcd, h24, in: sec min hour wday mday mon year cent, expected same order}
  localparam int NVEC = 21;
  localparam logic [129:0] VEC [NVEC] = '{
    {2'b11, 64'h05_00_00_01_01_01_08_20, 64'h06_00_00_01_01_01_08_20}, // R4
    {2'b11, 64'h09_30_12_02_14_07_15_20, 64'h10_30_12_02_14_07_15_20}, // R12
    {2'b11, 64'h59_14_08_02_14_07_15_20, 64'h00_15_08_02_14_07_15_20}, // R5
    {2'b11, 64'h59_59_10_02_14_07_15_20, 64'h00_00_11_02_14_07_15_20}, // R5
    {2'b11, 64'h59_59_23_06_15_03_15_20, 64'h00_00_00_00_16_03_15_20}, // R8
    {2'b11, 64'h59_59_23_02_31_01_15_20, 64'h00_00_00_03_01_02_15_20}, // R9
    {2'b01, 64'h3B_3B_17_01_1C_02_0F_14, 64'h00_00_00_02_01_03_0F_14}, // R9
    {2'b11, 64'h59_59_23_03_30_04_15_20, 64'h00_00_00_04_01_05_15_20}, // R9
    {2'b01, 64'h3B_3B_17_05_1E_0B_0F_14, 64'h00_00_00_06_01_0C_0F_14}, // R9
    {2'b11, 64'h59_59_23_00_30_00_15_20, 64'h00_00_00_01_01_01_15_20}, // R9
    {2'b11, 64'h59_59_23_04_31_12_99_19, 64'h00_00_00_05_01_01_00_20}, // R11
    {2'b01, 64'h3B_3B_17_04_1F_0C_63_13, 64'h00_00_00_05_01_01_00_14}, // R11
    {2'b01, 64'h3B_3B_17_04_1F_0C_08_14, 64'h00_00_00_05_01_01_09_14}, // R10
    {2'b10, 64'h59_59_11_01_05_05_15_20, 64'h00_00_80_01_05_05_15_20}, // R7
    {2'b10, 64'h59_59_91_04_10_06_15_20, 64'h00_00_00_05_11_06_15_20}, // R7
    {2'b00, 64'h3B_3B_85_01_05_05_0F_14, 64'h00_00_86_01_05_05_0F_14}, // R7
    {2'b10, 64'h59_59_89_01_05_05_15_20, 64'h00_00_90_01_05_05_15_20}, // R7
    {2'b01, 64'h3A_3B_17_06_1F_02_63_13, 64'h3B_3B_17_06_1F_02_63_13}, // R13
    {2'b01, 64'h3B_3B_17_03_0A_05_0F_14, 64'h00_00_00_04_0B_05_0F_14}, // R6
    {2'b11, 64'h59_59_23_01_09_09_15_20, 64'h00_00_00_02_10_09_15_20}, // R12
    {2'b11, 64'h59_59_23_02_30_09_15_20, 64'h00_00_00_03_01_10_15_20}  // R10
  };
  localparam string VEC_TAG [NVEC] = '{
    "R4", "R12", "R5", "R5", "R8", "R9", "R9", "R9", "R9", "R9", "R11",
    "R11", "R10", "R7", "R7", "R7", "R7", "R13", "R6", "R12", "R10"
  };

  function automatic logic [63:0] outWord();
    return {secOut, minOut, hourOut, wdayOut, mdayOut, monOut, yearOut, centOut};
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: record actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pulse actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic driveIn(logic [63:0] w);
    {secIn, minIn, hourIn, wdayIn, mdayIn, monIn, yearIn, centIn} = w;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check64("R1", outWord(), 64'h0);
    check1("R1", updPulse, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check1("R3", updPulse, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {bcdMode, hour24Mode} = VEC[i][129:128];
      driveIn(VEC[i][127:64]);
      tickIn = 1'b1;
      @(negedge clk);
      tickIn = 1'b0;
      check64(VEC_TAG[i], outWord(), VEC[i][63:0]);
      check1("R3", updPulse, 1'b1);
    end

    // R2: inputs and modes move, no tick: outputs keep the last record
    @(negedge clk);
    check1("R3", updPulse, 1'b0);
    driveIn(64'h11_22_13_04_15_06_17_08);
    bcdMode = 1'b0; hour24Mode = 1'b0;
    repeat (3) @(negedge clk);
    check64("R2", outWord(), VEC[NVEC-1][63:0]);
    check1("R2", updPulse, 1'b0);

    // R3: back-to-back ticks
    bcdMode = 1'b1; hour24Mode = 1'b1;
    driveIn(64'h20_10_05_01_02_03_04_20);
    tickIn = 1'b1;
    @(negedge clk);
    check64("R3", outWord(), 64'h21_10_05_01_02_03_04_20);
    check1("R3", updPulse, 1'b1);
    driveIn(64'h45_10_05_01_02_03_04_20);
    @(negedge clk);
    tickIn = 1'b0;
    check64("R3", outWord(), 64'h46_10_05_01_02_03_04_20);
    check1("R3", updPulse, 1'b1);
    @(negedge clk);
    check1("R3", updPulse, 1'b0);

    // R1: reset in mid-run clears the record
    rstN = 1'b0;
    @(negedge clk);
    check64("R1", outWord(), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule